// File: doc/BRIEF.md
# Iterative 16-bit Multiply Unit with CPU Interlock

This unit adds a hardware multiply to a small accumulator-based processor. The processor has two control strobes for it. The first copies the accumulator into a private multiplier register. The second starts a multiplication, and the accumulator value present at that moment becomes the multiplicand. The datapath is a radix-2 shift-and-add engine. It retires one multiplier bit per clock and then writes the full 32-bit unsigned product into a product register. The processor reads that register back one 16-bit half at a time.

A mode input is sampled with each start and sets how the processor waits. In blocking mode the unit raises `stall` for the whole run, so the processor stays frozen until the product exists. In background mode the unit works from its own copy of both operands and the processor keeps running. `stall` is raised only if the processor asks for a new start or a product read before the current run has finished.

Top module: `mulu_top`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `stall` and `done`, and clears the product register, so `prodOut` reads 0 for either half.
- R2: When `loadMplr` is high at a clock edge, `accIn` is copied into the multiplier register. A start uses the multiplier value that was loaded before the start edge.
- R3: When `startMul` is high at an edge while `busy` is low, `accIn` is captured as the multiplicand. `busy` is high from the next cycle.
- R4: The product register holds the unsigned 32-bit product of multiplier and multiplicand. `prodOut` shows bits 15:0 when `readHigh` is 0 and bits 31:16 when `readHigh` is 1.
- R5: `busy` stays high for exactly 17 cycles: 16 shift-add steps and one commit. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R6: When `bgMode` was 0 at the start edge, `stall` is high in every cycle in which `busy` is high.
- R7: When `bgMode` was 1 at the start edge, `stall` is high during `busy` only in cycles where `startMul` or `readReq` is high, and it falls when `busy` falls.
- R8: A `startMul` seen while `busy` is high is not accepted. If it is still held, it is accepted in the first cycle in which `busy` is low.
- R9: Loading the multiplier register during a run does not change the result of that run. The new value is used by the next start.
- R10: `prodOut` keeps showing the previous product for the whole run. It changes only when the new product is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accIn | input | 16 | Accumulator value from the CPU |
| loadMplr | input | 1 | Copy accIn into the multiplier register |
| startMul | input | 1 | Start a multiply, with accIn as the multiplicand |
| bgMode | input | 1 | Mode for this start: 1 background, 0 blocking |
| readReq | input | 1 | CPU is reading the product this cycle |
| readHigh | input | 1 | Half select for prodOut: 1 upper, 0 lower |
| prodOut | output | 16 | Selected half of the product register |
| busy | output | 1 | A multiply is in flight |
| done | output | 1 | One-cycle pulse when a product has been committed |
| stall | output | 1 | Hold the CPU |

## Verification
The assertions assume the CPU keeps `readHigh` steady whenever it wants the product to look stable. They also assume that a stalled request stays asserted until `stall` drops, which is how a frozen processor behaves. The stimulus changes inputs only at falling edges. It holds any start or read issued during a background run until `busy` clears. In blocking mode it issues no new request while the unit is busy, just as a stalled CPU could not.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operands, clear partial sum
    logic step;     // one shift-add iteration
    logic commit;   // move partial sum into product register
  } mulStrobe_t;
endpackage

// File: rtl/mulu_ctrl.sv
module mulu_ctrl
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startMul,
  input  logic       readReq,
  input  logic       bgMode,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       stall
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {IDLE, RUN, COMMIT} mulState_t;

  mulState_t state;
  logic [CW-1:0] stepCnt;
  logic bgRun;

  always_comb begin
    strobe.capture = (state == IDLE) && startMul;
    strobe.step    = (state == RUN);
    strobe.commit  = (state == COMMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      stepCnt <= '0;
      bgRun   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (state == COMMIT);
      case (state)
        IDLE: begin
          if (startMul) begin
            state   <= RUN;
            stepCnt <= '0;
            bgRun   <= bgMode;
          end
        end
        RUN: begin
          if (stepCnt == LAST) state <= COMMIT;
          else stepCnt <= stepCnt + 1'b1;
        end
        COMMIT:  state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign busy  = (state != IDLE);
  // blocking run: always hold; background run: hold only a new request
  assign stall = busy && (!bgRun || startMul || readReq);
endmodule

// File: rtl/mulu_dpath.sv
module mulu_dpath
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] accIn,
  input  logic         loadMplr,
  input  logic         readHigh,
  input  mulStrobe_t   strobe,
  output logic [W-1:0] prodOut
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mplrReg;
  logic [W-1:0]  shiftReg;
  logic [PW-1:0] mcandWork;
  logic [PW-1:0] partial;
  logic [PW-1:0] prodReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mplrReg   <= '0;
      shiftReg  <= '0;
      mcandWork <= '0;
      partial   <= '0;
      prodReg   <= '0;
    end else begin
      if (loadMplr) mplrReg <= accIn;
      if (strobe.capture) begin
        shiftReg  <= mplrReg;
        mcandWork <= {{W{1'b0}}, accIn};
        partial   <= '0;
      end else if (strobe.step) begin
        if (shiftReg[0]) partial <= partial + mcandWork;
        mcandWork <= mcandWork << 1;
        shiftReg  <= shiftReg >> 1;
      end
      if (strobe.commit) prodReg <= partial;
    end
  end

  assign prodOut = readHigh ? prodReg[PW-1:W] : prodReg[W-1:0];
endmodule

// File: rtl/mulu_top.sv
module mulu_top
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] accIn,
  input  logic         loadMplr,
  input  logic         startMul,
  input  logic         bgMode,
  input  logic         readReq,
  input  logic         readHigh,
  output logic [W-1:0] prodOut,
  output logic         busy,
  output logic         done,
  output logic         stall
);
  mulStrobe_t strobe;

  mulu_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .startMul(startMul), .readReq(readReq),
    .bgMode(bgMode), .strobe(strobe), .busy(busy), .done(done),
    .stall(stall)
  );

  mulu_dpath #(.W(W)) u_dpath (
    .clk(clk), .rst(rst), .accIn(accIn), .loadMplr(loadMplr),
    .readHigh(readHigh), .strobe(strobe), .prodOut(prodOut)
  );
endmodule

// File: rtl/mulu_checker.sv
module mulu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         startMul,
  input logic         bgMode,
  input logic         readReq,
  input logic         readHigh,
  input logic [W-1:0] prodOut,
  input logic         busy,
  input logic         done,
  input logic         stall
);
  localparam int LW = $clog2(W + 2) + 1;
  logic [LW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (rst) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (!busy && !done && !stall)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (startMul && !busy) |=> busy); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (runLen == LW'(W + 1))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R5
  AST_BLOCK_STALL: assert property (@(posedge clk) disable iff (rst) ($rose(busy) && !$past(bgMode)) |-> stall); // R6
  AST_HELD_REQ: assert property (@(posedge clk) disable iff (rst) (busy && (startMul || readReq)) |-> stall); // R7
  AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (rst) !busy |-> !stall); // R7
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst) ($past(busy) && busy && $stable(readHigh)) |-> $stable(prodOut)); // R10
endmodule

bind mulu_top mulu_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .startMul(startMul), .bgMode(bgMode),
  .readReq(readReq), .readHigh(readHigh), .prodOut(prodOut),
  .busy(busy), .done(done), .stall(stall)
);

// File: tb/mulu_top_test.sv
module mulu_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] accIn = '0;
  logic        loadMplr = 1'b0, startMul = 1'b0, bgMode = 1'b0;
  logic        readReq = 1'b0, readHigh = 1'b0;
  logic [15:0] prodOut;
  logic        busy, done, stall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  mulu_top uut (
    .clk(clk), .rst(rst), .accIn(accIn), .loadMplr(loadMplr),
    .startMul(startMul), .bgMode(bgMode), .readReq(readReq),
    .readHigh(readHigh), .prodOut(prodOut), .busy(busy), .done(done),
    .stall(stall)
  );

  always #10 clk = ~clk;  // 50 MHz

  // behavioural reference model
  int unsigned mMplr, mA, mB, mCnt;
  longint unsigned mProd;
  bit mBusy, mDone, mBg;

  always @(posedge clk) begin
    if (rst) begin
      mMplr = 0; mA = 0; mB = 0; mCnt = 0; mProd = 0;
      mBusy = 0; mDone = 0; mBg = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        if (mCnt == 17) begin
          mBusy = 0;
          mProd = longint'(mA) * longint'(mB);
          mDone = 1;
        end else mCnt++;
      end else if (startMul) begin
        mBusy = 1; mCnt = 1; mA = mMplr; mB = accIn; mBg = bgMode;
      end
      if (loadMplr) mMplr = accIn;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the edges
  always @(posedge clk) begin
    #5;
    if (!rst && !finished) begin
      logic [15:0] expOut;
      bit expStall;
      expOut = readHigh ? mProd[31:16] : mProd[15:0];
      expStall = mBusy && (!mBg || startMul || readReq);
      check(busy == mBusy, "R3 R5 busy", busy, mBusy);
      check(done == mDone, "R5 done", done, mDone);
      check(stall == expStall, "R6 R7 stall", stall, expStall);
      check(prodOut == expOut, "R4 R10 prodOut", prodOut, expOut);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic loadOp(input logic [15:0] v);
    tick(); accIn = v; loadMplr = 1; tick(); loadMplr = 0;
  endtask

  task automatic startOp(input logic [15:0] v, input bit bg);
    tick(); accIn = v; bgMode = bg; startMul = 1; tick(); startMul = 0;
  endtask

  task automatic waitIdle();
    while (busy) tick();
  endtask

  task automatic readBack(input logic [31:0] exp, input string tag);
    tick(); readReq = 1; readHigh = 0; #1;
    check(prodOut == exp[15:0], tag, prodOut, exp[15:0]);
    readHigh = 1; #1;
    check(prodOut == exp[31:16], tag, prodOut, exp[31:16]);
    tick(); readReq = 0; readHigh = 0;
  endtask

  task automatic mulCase(input logic [15:0] a, input logic [15:0] b, input bit bg);
    loadOp(a); startOp(b, bg); waitIdle();
    readBack(32'(a) * 32'(b), "R2 R3 R4 product");
  endtask

  initial begin
    repeat (3) tick();
    #1;
    check(!busy && !stall && !done && prodOut == 0, "R1 reset", {busy, stall, done}, 0);
    rst = 0;
    mulCase(16'd3, 16'd5, 0);
    mulCase(16'hFFFF, 16'hFFFF, 0);
    mulCase(16'h0000, 16'h1234, 1);
    mulCase(16'h8001, 16'h0001, 1);
    for (int i = 0; i < 6; i++) mulCase(16'($urandom), 16'($urandom), i[0]);

    // R9: reload multiplier during a background run
    loadOp(16'd7); startOp(16'd9, 1);
    loadOp(16'd100);
    waitIdle();
    readBack(32'd63, "R9 running result");
    startOp(16'd3, 1); waitIdle();
    readBack(32'd300, "R9 next start");

    // R8 R7: start and read held while a background run is in flight
    loadOp(16'd11); startOp(16'd13, 1);
    tick(); readReq = 1; tick();
    check(stall == 1, "R7 held read", stall, 1);
    readReq = 0;
    accIn = 16'd2; startMul = 1; bgMode = 1; tick();
    check(stall == 1 && busy == 1, "R8 start held", stall, 1);
    while (busy) tick();
    tick(); startMul = 0;  // accepted in first idle cycle
    #1;
    check(busy == 1, "R8 accepted after run", busy, 1);
    waitIdle();
    readBack(32'd22, "R8 second product");

    // R6: blocking run keeps stall high
    loadOp(16'd4); startOp(16'd4, 0);
    #1;
    check(stall == 1, "R6 blocking stall", stall, 1);
    waitIdle();
    readBack(32'd16, "R6 product");

    // R1: reset mid-run
    loadOp(16'd5); startOp(16'd5, 0);
    tick(); rst = 1; tick(); tick(); #1;
    check(!busy && !stall && prodOut == 0, "R1 reset mid-run", busy, 0);
    rst = 0;
    repeat (2) tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog R5 actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule